// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns single read and write requests from the processor side into timed cycles on an external memory bus. The address space is cut into numbered regions. Each region, called a slot here, has its own small settings word: whether the device on it is 8 or 16 bits wide, whether a read keeps chip-select for one extra bus cycle, and how long the data bus must stay quiet after a read. Slot accesses are timed in half bus cycles. One clock tick of `clk` is half a bus cycle, so turnaround delays of 0.5, 1.5, 2.5 and 3.5 bus cycles are exact.

The requester presents the address, the size (byte or halfword), the direction and the write data. It holds them until a one-cycle acknowledge returns, which carries read data or an error flag. A halfword sent to an 8-bit device becomes two byte cycles, lower address first. One special slot at 0x300000–0x3FFFFF ignores its width bit: its lower half always behaves as 8-bit and its upper half always behaves as 16-bit. The settings live in flops that only the cold reset clears. The hot reset returns only the sequencer to idle.

Top module: `extBusSequencer`

## Requirements
- R1: Address bits [23:20] select the slot. The values 4, 5, 6 and 7 select group slots 0 to 3, and the value 3 selects the split slot 4, which drives `extCsN[4]`. Any other address gets an acknowledge with `ackErr`=1 and drives no chip-select, read strobe or write strobe.
- R2: A settings word has width8 in bit 0. When width8 is 1, a halfword access becomes two back-to-back byte cycles. The first is at the request address and the second at the request address plus 1. The first byte read fills `ackRdata[7:0]` and the second fills `ackRdata[15:8]`. When width8 is 0, a halfword access is one 16-bit cycle.
- R3: In slot 4, addresses with bit 19 at 0 are always treated as 8-bit and addresses with bit 19 at 1 are always treated as 16-bit, whatever width8 holds.
- R4: Each byte cycle or word cycle lasts one setup tick with chip-select only, followed by the strobe. The strobe lasts 2 ticks. It lasts 1 tick when `dblSpeedEn`=1 and the slot's x1Speed bit (bit 4) is 0.
- R5: When readHold (bit 1) is 1, every read cycle keeps chip-select for 2 more ticks after the read strobe. Writes are never lengthened.
- R6: Let the delay code be bits [3:2]. After a read, with the next request already waiting, the number of ticks with no chip-select before the next cycle is max(2, 2×code+1). After a write the number is 2.
- R7: Cold reset puts every slot's settings to 5'b01100: delay code 11, 16-bit, no hold, x1Speed 0. `cfgRdata[4:0]` returns the settings of the slot that `cfgSel` names.
- R8: Hot reset returns the sequencer to idle with every strobe and chip-select inactive. It leaves all settings unchanged.
- R9: Writes to bits [7:5] of a settings word change neither the stored bits [4:0] nor any bus timing.
- R10: `extDataOe` is high only during the setup and strobe ticks of write cycles, and it is never high together with the read strobe. In a 16-bit cycle the write data goes out whole. In a byte cycle it goes out on [7:0], low byte first.
- R11: The read and write strobes are never both active. At most one chip-select is active at a time. `ackValid` is a single-cycle pulse.
- R12: A byte read returns the device's [7:0] in `ackRdata[7:0]`, with zero in `ackRdata[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bus-cycle timing clock |
| coldRstN | input | 1 | Active-low reset of sequencer and settings |
| hotRstN | input | 1 | Active-low reset of sequencer only |
| dblSpeedEn | input | 1 | Enables the short strobe for slots whose x1Speed bit is 0 |
| cfgWe | input | 1 | Settings write enable |
| cfgSel | input | 3 | Slot whose settings are written or read |
| cfgWdata | input | 8 | Settings write data |
| cfgRdata | output | 8 | Settings of the selected slot in [4:0] |
| reqValid | input | 1 | Request pending, held until acknowledge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 1 | 1 = halfword, 0 = byte |
| reqAddr | input | 24 | Request byte address |
| reqWdata | input | 16 | Write data |
| ackValid | output | 1 | One-cycle completion pulse |
| ackErr | output | 1 | Address matched no slot |
| ackRdata | output | 16 | Read data |
| extAddr | output | 24 | External address |
| extCsN | output | 5 | Active-low chip-selects, one per slot |
| extRdN | output | 1 | Active-low read strobe |
| extWrN | output | 1 | Active-low write strobe |
| extDataOut | output | 16 | Data driven toward the device |
| extDataOe | output | 1 | Output enable of the data bus |
| extDataIn | input | 16 | Data returned by the device |

## Verification
The assertions assume that the requester keeps address, size, direction and write data stable from the raising of `reqValid` until the acknowledge. They also assume that no settings word is written while a cycle is in progress, and that halfword addresses are even. The stimulus keeps to this. Every access is issued and then waited on to completion. Settings are written only between accesses, with `reqValid` low. All halfword addresses are built with bit 0 cleared. Hot reset is applied in the middle of an access only after the request has been withdrawn.

// File: rtl/seqPkg.sv
package seqPkg;

  typedef struct packed {
    logic       x1Speed;
    logic [1:0] delayCode;
    logic       readHold;
    logic       width8;
  } slotCfgT;

  localparam int CFG_W = $bits(slotCfgT);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } seqStateT;

  typedef struct packed {
    logic busActive;
    logic rdActive;
    logic wrActive;
    logic dataOe;
    logic second;
    logic capLo;
    logic capHi;
  } strobeT;

endpackage

// File: rtl/busData.sv
module busData
  import seqPkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int NGROUPS       = 4,
  parameter int SPLIT_REGION  = 3,
  parameter int GROUP_REGION0 = 4,
  localparam int NSLOTS       = NGROUPS + 1,
  localparam int SLOT_W       = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              seqRstN,
  input  logic              dblSpeedEn,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSel,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSize,
  input  logic [15:0]       reqWdata,
  input  strobeT            stb,
  output logic              decHit,
  output logic              decWidth8,
  output logic              decHold,
  output logic [1:0]        decCode,
  output logic              decShort,
  output logic [ADDR_W-1:0] extAddr,
  output logic [NSLOTS-1:0] extCsN,
  output logic [15:0]       extDataOut,
  input  logic [15:0]       extDataIn,
  output logic [15:0]       ackRdata
);

  localparam int REGION_W = 4;
  localparam slotCfgT CFG_DEFAULT = '{x1Speed: 1'b0, delayCode: 2'b11,
                                      readHold: 1'b0, width8: 1'b0};

  slotCfgT cfgMem [NSLOTS];
  logic [REGION_W-1:0] region;
  logic [NSLOTS-1:0]   slotHit;
  slotCfgT             selCfg;
  logic                fullWidth;

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      for (int s = 0; s < NSLOTS; s++) cfgMem[s] <= CFG_DEFAULT;
    end else if (cfgWe) begin
      for (int s = 0; s < NSLOTS; s++)
        if (cfgSel == SLOT_W'(s)) cfgMem[s] <= cfgWdata[CFG_W-1:0];
    end
  end

  always_comb begin
    cfgRdata = '0;
    for (int s = 0; s < NSLOTS; s++)
      if (cfgSel == SLOT_W'(s)) cfgRdata[CFG_W-1:0] = cfgMem[s];
  end

  assign region = reqAddr[ADDR_W-1 -: REGION_W];

  for (genvar g = 0; g < NSLOTS; g++) begin : gDecode
    localparam int REGION_OF = (g == NGROUPS) ? SPLIT_REGION : GROUP_REGION0 + g;
    assign slotHit[g] = (region == REGION_W'(REGION_OF));
  end

  always_comb begin
    selCfg = '0;
    for (int s = 0; s < NSLOTS; s++)
      if (slotHit[s]) selCfg = cfgMem[s];
  end

  assign decHit    = |slotHit;
  assign decWidth8 = slotHit[NGROUPS] ? ~reqAddr[ADDR_W-REGION_W-1] : selCfg.width8;
  assign decHold   = selCfg.readHold;
  assign decCode   = selCfg.delayCode;
  assign decShort  = dblSpeedEn & ~selCfg.x1Speed;

  assign fullWidth  = reqSize & ~decWidth8;
  assign extCsN     = ~(slotHit & {NSLOTS{stb.busActive}});
  assign extAddr    = reqAddr + ADDR_W'(stb.second);
  assign extDataOut = fullWidth ? reqWdata
                                : {8'h00, stb.second ? reqWdata[15:8] : reqWdata[7:0]};

  always_ff @(posedge clk or negedge seqRstN) begin
    if (!seqRstN) begin
      ackRdata <= '0;
    end else if (stb.capLo) begin
      ackRdata <= fullWidth ? extDataIn : {8'h00, extDataIn[7:0]};
    end else if (stb.capHi) begin
      ackRdata[15:8] <= extDataIn[7:0];
    end
  end

endmodule

// File: rtl/busCtrl.sv
module busCtrl
  import seqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqSize,
  input  logic       decHit,
  input  logic       decWidth8,
  input  logic       decHold,
  input  logic [1:0] decCode,
  input  logic       decShort,
  output strobeT     stb,
  output logic       ackValid,
  output logic       ackErr
);

  seqStateT   state;
  logic       tick;
  logic [2:0] turnCnt;
  logic       second;
  logic       errFlag;
  logic       strobeLast;
  logic       subEnd;
  logic       lastSub;

  assign strobeLast = (state == ST_STROBE) && !tick;
  assign subEnd     = (strobeLast && (reqWrite || !decHold)) ||
                      ((state == ST_HOLD) && !tick);
  assign lastSub    = !(reqSize && decWidth8) || second;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tick    <= 1'b0;
      turnCnt <= '0;
      second  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (turnCnt != 0) turnCnt <= turnCnt - 3'd1;
      case (state)
        ST_IDLE: begin
          if (reqValid && turnCnt == 0) begin
            second  <= 1'b0;
            errFlag <= !decHit;
            state   <= decHit ? ST_SETUP : ST_DONE;
          end
        end
        ST_SETUP: begin
          state <= ST_STROBE;
          tick  <= !decShort;
        end
        ST_STROBE: begin
          if (tick) tick <= 1'b0;
          else if (!reqWrite && decHold) begin
            state <= ST_HOLD;
            tick  <= 1'b1;
          end
        end
        ST_HOLD: if (tick) tick <= 1'b0;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (subEnd) begin
        if (!lastSub) begin
          second <= 1'b1;
          state  <= ST_SETUP;
        end else begin
          state <= ST_DONE;
          if (!reqWrite) turnCnt <= {decCode, 1'b0};
        end
      end
    end
  end

  always_comb begin
    stb           = '0;
    stb.busActive = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    stb.rdActive  = (state == ST_STROBE) && !reqWrite;
    stb.wrActive  = (state == ST_STROBE) && reqWrite;
    stb.dataOe    = reqWrite && ((state == ST_SETUP) || (state == ST_STROBE));
    stb.second    = second;
    stb.capLo     = strobeLast && !reqWrite && !second;
    stb.capHi     = strobeLast && !reqWrite && second;
  end

  assign ackValid = (state == ST_DONE);
  assign ackErr   = (state == ST_DONE) && errFlag;

endmodule

// File: rtl/extBusSequencer.sv
module extBusSequencer
  import seqPkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int NGROUPS       = 4,
  parameter int SPLIT_REGION  = 3,
  parameter int GROUP_REGION0 = 4,
  localparam int NSLOTS       = NGROUPS + 1,
  localparam int SLOT_W       = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              hotRstN,
  input  logic              dblSpeedEn,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSel,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  output logic              ackValid,
  output logic              ackErr,
  output logic [15:0]       ackRdata,
  output logic [ADDR_W-1:0] extAddr,
  output logic [NSLOTS-1:0] extCsN,
  output logic              extRdN,
  output logic              extWrN,
  output logic [15:0]       extDataOut,
  output logic              extDataOe,
  input  logic [15:0]       extDataIn
);

  strobeT     stb;
  logic       seqRstN;
  logic       decHit, decWidth8, decHold, decShort;
  logic [1:0] decCode;

  assign seqRstN = coldRstN & hotRstN;

  busCtrl uCtrl (
    .clk(clk), .rstN(seqRstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .decHit(decHit), .decWidth8(decWidth8), .decHold(decHold),
    .decCode(decCode), .decShort(decShort), .stb(stb),
    .ackValid(ackValid), .ackErr(ackErr)
  );

  busData #(
    .ADDR_W(ADDR_W), .NGROUPS(NGROUPS),
    .SPLIT_REGION(SPLIT_REGION), .GROUP_REGION0(GROUP_REGION0)
  ) uData (
    .clk(clk), .coldRstN(coldRstN), .seqRstN(seqRstN), .dblSpeedEn(dblSpeedEn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata), .stb(stb),
    .decHit(decHit), .decWidth8(decWidth8), .decHold(decHold), .decCode(decCode),
    .decShort(decShort), .extAddr(extAddr), .extCsN(extCsN),
    .extDataOut(extDataOut), .extDataIn(extDataIn), .ackRdata(ackRdata)
  );

  assign extRdN    = ~stb.rdActive;
  assign extWrN    = ~stb.wrActive;
  assign extDataOe = stb.dataOe;

endmodule

// File: rtl/extBusSequencer_chk.sv
module extBusSequencer_chk #(
  parameter int NSLOTS = 5
) (
  input logic              clk,
  input logic              coldRstN,
  input logic              hotRstN,
  input logic [NSLOTS-1:0] extCsN,
  input logic              extRdN,
  input logic              extWrN,
  input logic              extDataOe,
  input logic              ackValid,
  input logic              ackErr
);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    !(!extRdN && !extWrN));

  // R11
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    $onehot0(~extCsN));

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    ackValid |=> !ackValid);

  // R10
  oe_read_chk: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    extDataOe |-> extRdN);

  // R10
  wr_oe_chk: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    !extWrN |-> extDataOe);

  // R1
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    (!extRdN || !extWrN) |-> (extCsN != '1));

  // R1
  err_quiet_chk: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    ackErr |-> (ackValid && (&extCsN) && $past(&extCsN)));

endmodule

bind extBusSequencer extBusSequencer_chk #(.NSLOTS(NSLOTS)) uChk (
  .clk(clk), .coldRstN(coldRstN), .hotRstN(hotRstN), .extCsN(extCsN),
  .extRdN(extRdN), .extWrN(extWrN), .extDataOe(extDataOe),
  .ackValid(ackValid), .ackErr(ackErr)
);

// File: tb/extBusSequencer_test.sv
module extBusSequencer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        coldRstN, hotRstN, dblSpeedEn, cfgWe;
  logic [2:0]  cfgSel;
  logic [7:0]  cfgWdata, cfgRdata;
  logic        reqValid, reqWrite, reqSize;
  logic [23:0] reqAddr;
  logic [15:0] reqWdata;
  logic        ackValid, ackErr;
  logic [15:0] ackRdata;
  logic [23:0] extAddr;
  logic [4:0]  extCsN;
  logic        extRdN, extWrN, extDataOe;
  logic [15:0] extDataOut, extDataIn;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extBusSequencer uut (
    .clk(clk), .coldRstN(coldRstN), .hotRstN(hotRstN), .dblSpeedEn(dblSpeedEn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ackValid(ackValid), .ackErr(ackErr), .ackRdata(ackRdata),
    .extAddr(extAddr), .extCsN(extCsN), .extRdN(extRdN), .extWrN(extWrN),
    .extDataOut(extDataOut), .extDataOe(extDataOe), .extDataIn(extDataIn)
  );

  function automatic logic [15:0] devWord(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[23:16], a[23:16]};
  endfunction

  assign extDataIn = !extRdN ? devWord(extAddr) : 16'hDEAD;

  // bus monitor, sampled one time unit after each rising edge
  int          csTot = 0, rdTot = 0, wrTot = 0, oeTot = 0;
  int          idleRun = 0, lastGap = 0;
  logic [23:0] accBase = '0;
  logic [15:0] w0Data = '0, w1Data = '0;

  always @(posedge clk) begin
    #1;
    if (extCsN != '1) begin
      if (idleRun != 0) lastGap = idleRun;
      idleRun = 0;
      csTot++;
    end else begin
      idleRun++;
    end
    if (!extRdN) rdTot++;
    if (!extWrN) begin
      wrTot++;
      if (extAddr == accBase) w0Data = extDataOut;
      if (extAddr == accBase + 24'd1) w1Data = extDataOut;
    end
    if (extDataOe) oeTot++;
  end

  task automatic chkEq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input int slot, input logic [7:0] val);
    cfgWe = 1'b1; cfgSel = 3'(slot); cfgWdata = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgCheck(input string tag, input int slot, input logic [4:0] exp);
    cfgSel = 3'(slot);
    #1;
    chkEq(tag, "settings readback", int'(cfgRdata[4:0]), int'(exp));
  endtask

  task automatic issue(input bit wr, input bit sz, input logic [23:0] a, input logic [15:0] wd);
    int w = 0;
    accBase = a;
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    while (!ackValid && w < 100) begin
      @(negedge clk);
      w++;
    end
    reqValid = 1'b0;
  endtask

  // one access with all expectations computed from the settings
  task automatic access(input bit wr, input bit sz, input logic [23:0] a, input logic [15:0] wd,
                        input bit w8, input bit hold, input bit shortS, input int expGap,
                        input string dtag);
    int cs0 = csTot, rd0 = rdTot, wr0 = wrTot, oe0 = oeTot;
    int n = (sz && w8) ? 2 : 1;
    int s = shortS ? 1 : 2;
    int h = (!wr && hold) ? 2 : 0;
    logic [15:0] expR;
    issue(wr, sz, a, wd);
    chkEq("R1", "ack without error", int'(ackValid && !ackErr), 1);
    chkEq(hold ? "R5" : "R4", "chip-select ticks", csTot - cs0, n * (1 + s + h));
    chkEq("R4", "strobe ticks", wr ? wrTot - wr0 : rdTot - rd0, n * s);
    chkEq("R10", "output-enable ticks", oeTot - oe0, wr ? n * (1 + s) : 0);
    if (expGap >= 0) chkEq("R6", "turnaround gap", lastGap, expGap);
    if (!wr) begin
      if (!sz) expR = {8'h00, devWord(a)[7:0]};
      else if (w8) expR = {devWord(a + 24'd1)[7:0], devWord(a)[7:0]};
      else expR = devWord(a);
      chkEq(dtag, "read data", int'(ackRdata), int'(expR));
    end else begin
      if (sz && !w8) chkEq("R10", "word write data", int'(w0Data), int'(wd));
      else chkEq("R10", "low byte write data", int'(w0Data), int'({8'h00, wd[7:0]}));
      if (sz && w8) chkEq(dtag, "high byte write data", int'(w1Data), int'({8'h00, wd[15:8]}));
    end
  endtask

  task automatic errAccess(input logic [23:0] a);
    int cs0 = csTot, st0 = rdTot + wrTot;
    issue(1'b0, 1'b1, a, 16'h0);
    chkEq("R1", "error acknowledge", int'(ackErr), 1);
    chkEq("R1", "no chip-select on error", csTot - cs0, 0);
    chkEq("R1", "no strobe on error", rdTot + wrTot - st0, 0);
  endtask

  task automatic idleCheck(input string tag);
    chkEq(tag, "chip-selects idle", int'(extCsN), 5'h1F);
    chkEq(tag, "strobes idle", int'({extRdN, extWrN}), 3);
    chkEq(tag, "oe and ack idle", int'({extDataOe, ackValid}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    coldRstN = 1'b0; hotRstN = 1'b1; dblSpeedEn = 1'b0; cfgWe = 1'b0;
    cfgSel = '0; cfgWdata = '0; reqValid = 1'b0; reqWrite = 1'b0;
    reqSize = 1'b0; reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    coldRstN = 1'b1;
    @(negedge clk);

    // R7 reset state and defaults
    idleCheck("R7");
    for (int sl = 0; sl < 5; sl++) cfgCheck("R7", sl, 5'b01100);

    // R1 unmapped addresses
    errAccess(24'h200000);
    errAccess(24'hA01234);

    // sweep of every settings word, speed mode and slot
    for (int sl = 0; sl < 5; sl++) begin
      for (int cv = 0; cv < 32; cv++) begin
        for (int dbl = 0; dbl < 2; dbl++) begin
          for (int hf = 0; hf < ((sl == 4) ? 2 : 1); hf++) begin
            logic [23:0] a;
            bit w8, hold, shortS;
            int code, gRead;
            string dtag;
            cfgWrite(sl, {3'b101, 5'(cv)});
            cfgCheck("R9", sl, 5'(cv));
            dblSpeedEn = dbl[0];
            if (sl == 4) a = (hf == 1) ? 24'h3812A4 : 24'h3012A4;
            else a = {4'(4 + sl), 20'h012A4};
            a = a + 24'(cv * 32);
            w8 = (sl == 4) ? (hf == 0) : cv[0];
            hold = cv[1];
            code = (cv >> 2) & 3;
            shortS = dbl[0] && !cv[4];
            gRead = (2 * code + 1 > 2) ? 2 * code + 1 : 2;
            dtag = (sl == 4) ? "R3" : "R2";
            access(1'b0, 1'b1, a, 16'h0, w8, hold, shortS, -1, dtag);
            access(1'b1, 1'b1, a, 16'(16'hC3A1 + cv), w8, hold, shortS, gRead, dtag);
            access(1'b0, 1'b0, a + 24'd2, 16'h0, w8, hold, shortS, 2, "R12");
            access(1'b1, 1'b0, a + 24'd4, 16'(16'h7E10 + cv), w8, hold, shortS, gRead, "R12");
          end
        end
      end
    end

    // R8 hot reset in the middle of an access keeps the settings
    dblSpeedEn = 1'b0;
    cfgWrite(1, 8'h07);
    reqValid = 1'b1; reqWrite = 1'b0; reqSize = 1'b1; reqAddr = 24'h500040;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    hotRstN = 1'b0;
    @(negedge clk);
    idleCheck("R8");
    @(negedge clk);
    hotRstN = 1'b1;
    @(negedge clk);
    cfgCheck("R8", 1, 5'b00111);
    access(1'b0, 1'b1, 24'h500040, 16'h0, 1'b1, 1'b1, 1'b0, -1, "R8");

    // R7 cold reset restores defaults
    coldRstN = 1'b0;
    @(negedge clk);
    coldRstN = 1'b1;
    @(negedge clk);
    idleCheck("R7");
    for (int sl = 0; sl < 5; sl++) cfgCheck("R7", sl, 5'b01100);
    access(1'b0, 1'b1, 24'h600100, 16'h0, 1'b0, 1'b0, 1'b0, -1, "R7");
    access(1'b1, 1'b1, 24'h600100, 16'hBEEF, 1'b0, 1'b0, 1'b0, 7, "R7");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule